// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between the output lanes of a PWM generator and the device pins. It watches a small set of fault inputs and, while a fault is in force, replaces every PWM lane with a per-lane safe level. Each fault input has its own polarity and its own enable. A selector decides whether a second group of on-chip digital comparator conditions also counts as fault sources.

A fault can outlast its cause in two ways. In latch mode a fault stays in force after its input releases, and software must clear it by writing a one to that input's status bit. In minimum-period mode a down-counter keeps the fault in force for a programmed number of clocks after the last active cycle. Per-input status bits record every fault that has been seen, and a write of one clears them.

A four-state machine sets the override. The states are IDLE (pass-through), ACTIVE (a source is asserting), STRETCH (the minimum-period counter is running) and LATCHED (waiting for a clear). The transitions are:
- IDLE to ACTIVE on any live source.
- ACTIVE to LATCHED when the source releases while latch mode holds a latched input.
- Otherwise ACTIVE to STRETCH when the source releases with minimum-period mode on and a non-zero period.
- Otherwise ACTIVE to IDLE.
- STRETCH back to ACTIVE on a new source, or to IDLE when the count expires.
- LATCHED back to ACTIVE on a new source, or to IDLE once every latched input is cleared.

Top module: `fault_guard_top`

## Requirements
- R1: After reset, fault_o is 0, status_o is 0, and pwm_o equals pwm_i.
- R2: Each fault pin passes through a two-flop synchronizer. A pin change driven before clock edge k shows on pin_stat_o after edge k+1, and raises fault_o after edge k+2.
- R3: sense_i bit i = 1 makes pin i active low, and 0 makes it active high. A pin whose pin_en_i bit is 0 never raises a fault and reads 0 in pin_stat_o.
- R4: While fault_o is 1, each pwm_o bit j equals safe_val_i bit j. While fault_o is 0, pwm_o equals pwm_i.
- R5: Digital comparator condition i (dcmp_i bit i, gated by dcmp_en_i bit i, not synchronized) counts as a fault only while use_dcmp_i is 1. When it counts, it raises fault_o after the next clock edge.
- R6: status_o bit i is set by an active source i and holds until a 1 on clr_i bit i. If source i is still active in the clearing cycle, the bit stays set.
- R7: With latch_en_i = 1, fault_o stays 1 after all sources release, until every latched input is cleared through clr_i. It drops on the clearing edge.
- R8: With minper_en_i = 1 and minper_i = N > 0, fault_o stays 1 for N more cycles after the first cycle in which no source is active. The counter reloads to N on every active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_pin_i | input | 4 | Asynchronous fault pins |
| dcmp_i | input | 4 | Synchronous digital comparator conditions |
| sense_i | input | 4 | Per-pin polarity, 1 = active low |
| pin_en_i | input | 4 | Per-pin enable |
| dcmp_en_i | input | 4 | Per-condition enable |
| use_dcmp_i | input | 1 | Include comparator conditions as sources |
| latch_en_i | input | 1 | Latch mode |
| minper_en_i | input | 1 | Minimum-period mode |
| minper_i | input | 16 | Minimum fault period in clocks |
| clr_i | input | 4 | Write-one-to-clear pulses for status and latch |
| pwm_i | input | 8 | Generator lanes |
| safe_val_i | input | 8 | Per-lane safe level |
| pwm_o | output | 8 | Lanes to pins |
| fault_o | output | 1 | Override in force |
| status_o | output | 4 | Sticky per-input fault status |
| pin_stat_o | output | 4 | Enabled, polarity-corrected pin levels now |
| dcmp_stat_o | output | 4 | Enabled comparator conditions now |

## Verification
The override is tried with a plain active-high pin, an active-low pin, a disabled pin and a comparator condition with its selector off and then on. These cases separate the polarity, enable and source-select paths. Each release is then run three ways: with no mode (drop after the sync delay), with latch mode (hold until clear) and with a one-cycle pulse under minimum-period mode (hold exactly N extra cycles). Clearing while the source is still active shows that the input wins over the clear.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic [1:0] {
        FG_IDLE    = 2'd0,
        FG_ACTIVE  = 2'd1,
        FG_STRETCH = 2'd2,
        FG_LATCHED = 2'd3
    } fg_state_e;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/fg_src.sv
module fg_src #(
    parameter int NF = 4
) (
    input  logic [NF-1:0] pin_sync_i,
    input  logic [NF-1:0] dcmp_i,
    input  logic [NF-1:0] sense_i,
    input  logic [NF-1:0] pin_en_i,
    input  logic [NF-1:0] dcmp_en_i,
    input  logic          use_dcmp_i,
    output logic [NF-1:0] pin_act_o,
    output logic [NF-1:0] dcmp_act_o,
    output logic [NF-1:0] src_act_o,
    output logic          live_o
);
    always_comb begin
        pin_act_o  = (pin_sync_i ^ sense_i) & pin_en_i;
        dcmp_act_o = dcmp_i & dcmp_en_i;
        src_act_o  = pin_act_o | (use_dcmp_i ? dcmp_act_o : '0);
        live_o     = |src_act_o;
    end
endmodule

// File: rtl/fg_status.sv
module fg_status #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] src_act_i,
    input  logic [NF-1:0] clr_i,
    input  logic          latch_en_i,
    output logic [NF-1:0] status_o,
    output logic [NF-1:0] lat_nxt_o
);
    logic [NF-1:0] status_q;
    logic [NF-1:0] lat_q;

    // A clear loses against a source that is active in the same cycle.
    assign lat_nxt_o = (lat_q & ~clr_i) | (src_act_i & {NF{latch_en_i}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            lat_q    <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | src_act_i;
            lat_q    <= lat_nxt_o;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
    import fg_pkg::*;
#(
    parameter int NF    = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live_i,
    input  logic [NF-1:0]    lat_nxt_i,
    input  logic             latch_en_i,
    input  logic             minper_en_i,
    input  logic [CNT_W-1:0] minper_i,
    output fg_state_e        state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fault_o
);
    fg_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             stretch_ok;

    assign stretch_ok = minper_en_i && (minper_i != '0);

    // State register and period counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FG_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (live_i)
                cnt_q <= minper_i;
            else if (st_q == FG_STRETCH && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FG_IDLE: begin
                if (live_i) st_d = FG_ACTIVE;
            end
            FG_ACTIVE: begin
                if (!live_i) begin
                    if (latch_en_i && (|lat_nxt_i)) st_d = FG_LATCHED;
                    else if (stretch_ok)            st_d = FG_STRETCH;
                    else                            st_d = FG_IDLE;
                end
            end
            FG_STRETCH: begin
                if (live_i)                              st_d = FG_ACTIVE;
                else if (!minper_en_i || cnt_q <= 'd1)   st_d = FG_IDLE;
            end
            FG_LATCHED: begin
                if (live_i)              st_d = FG_ACTIVE;
                else if (~|lat_nxt_i)    st_d = FG_IDLE;
            end
            default: st_d = FG_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        fault_o = (st_q != FG_IDLE);
    end

    assign state_o = st_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/fault_guard_top.sv
module fault_guard_top
    import fg_pkg::*;
#(
    parameter int NF    = 4,
    parameter int NOUT  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NF-1:0]    fault_pin_i,
    input  logic [NF-1:0]    dcmp_i,
    input  logic [NF-1:0]    sense_i,
    input  logic [NF-1:0]    pin_en_i,
    input  logic [NF-1:0]    dcmp_en_i,
    input  logic             use_dcmp_i,
    input  logic             latch_en_i,
    input  logic             minper_en_i,
    input  logic [CNT_W-1:0] minper_i,
    input  logic [NF-1:0]    clr_i,
    input  logic [NOUT-1:0]  pwm_i,
    input  logic [NOUT-1:0]  safe_val_i,
    output logic [NOUT-1:0]  pwm_o,
    output logic             fault_o,
    output logic [NF-1:0]    status_o,
    output logic [NF-1:0]    pin_stat_o,
    output logic [NF-1:0]    dcmp_stat_o
);
    logic [NF-1:0]    pin_sync;
    logic [NF-1:0]    src_act;
    logic [NF-1:0]    lat_nxt;
    logic             live;
    fg_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;

    fg_sync #(.W(NF)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(fault_pin_i), .q_o(pin_sync)
    );

    fg_src #(.NF(NF)) u_src (
        .pin_sync_i(pin_sync), .dcmp_i(dcmp_i), .sense_i(sense_i),
        .pin_en_i(pin_en_i), .dcmp_en_i(dcmp_en_i), .use_dcmp_i(use_dcmp_i),
        .pin_act_o(pin_stat_o), .dcmp_act_o(dcmp_stat_o),
        .src_act_o(src_act), .live_o(live)
    );

    fg_status #(.NF(NF)) u_status (
        .clk(clk), .rst_n(rst_n), .src_act_i(src_act), .clr_i(clr_i),
        .latch_en_i(latch_en_i), .status_o(status_o), .lat_nxt_o(lat_nxt)
    );

    fg_ctrl #(.NF(NF), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .live_i(live), .lat_nxt_i(lat_nxt),
        .latch_en_i(latch_en_i), .minper_en_i(minper_en_i), .minper_i(minper_i),
        .state_o(st_q), .cnt_o(cnt_q), .fault_o(fault_o)
    );

    for (genvar j = 0; j < NOUT; j++) begin : g_lane
        assign pwm_o[j] = fault_o ? safe_val_i[j] : pwm_i[j];
    end
endmodule

// File: rtl/fg_checker.sv
module fg_checker
    import fg_pkg::*;
#(
    parameter int NF    = 4,
    parameter int NOUT  = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             live,
    input fg_state_e        st_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [NF-1:0]    clr_i,
    input logic             use_dcmp_i,
    input logic [NOUT-1:0]  pwm_i,
    input logic [NOUT-1:0]  safe_val_i,
    input logic [NOUT-1:0]  pwm_o,
    input logic             fault_o,
    input logic [NF-1:0]    status_o,
    input logic [NF-1:0]    pin_stat_o,
    input logic [NF-1:0]    dcmp_stat_o
);
    // R2: a live source forces the override on the next edge.
    p_live_forces_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> fault_o);

    // R4: lane override follows the fault state.
    p_override_safe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (pwm_o == safe_val_i));
    p_override_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (pwm_o == pwm_i));

    // R5: a status bit only rises from an enabled, selected source.
    p_rise_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o)) &
                  ~$past(pin_stat_o | (use_dcmp_i ? dcmp_stat_o : '0))) == '0);

    // R6: set status bits hold unless cleared.
    p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_o & ~clr_i)) & ~status_o) == '0);

    // R7: a latched fault holds without a clear.
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FG_LATCHED && clr_i == '0) |=> fault_o);

    // R8: a running stretch count keeps the fault on.
    p_stretch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FG_STRETCH && cnt_q > 'd1) |=> fault_o);
endmodule

bind fault_guard_top fg_checker #(.NF(NF), .NOUT(NOUT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .live(live), .st_q(st_q), .cnt_q(cnt_q),
    .clr_i(clr_i), .use_dcmp_i(use_dcmp_i), .pwm_i(pwm_i),
    .safe_val_i(safe_val_i), .pwm_o(pwm_o), .fault_o(fault_o),
    .status_o(status_o), .pin_stat_o(pin_stat_o), .dcmp_stat_o(dcmp_stat_o)
);

// File: tb/test_fault_guard_top.sv
module test_fault_guard_top;
    localparam logic [7:0] PASS = 8'hA5;
    localparam logic [7:0] SAFE = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fault_pin_i = '0, dcmp_i = '0, sense_i = '0, pin_en_i = '0;
    logic [3:0]  dcmp_en_i = '0, clr_i = '0;
    logic        use_dcmp_i = 1'b0, latch_en_i = 1'b0, minper_en_i = 1'b0;
    logic [15:0] minper_i = '0;
    logic [7:0]  pwm_i = PASS, safe_val_i = SAFE;
    logic [7:0]  pwm_o;
    logic        fault_o;
    logic [3:0]  status_o, pin_stat_o, dcmp_stat_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] pwm;
        logic       flt;
        logic [3:0] st;
        logic       chk_ps;
        logic [3:0] ps;
        string      req;
    } exp_t;
    exp_t q[$];

    fault_guard_top i_fault_guard_top (
        .clk(clk), .rst_n(rst_n), .fault_pin_i(fault_pin_i), .dcmp_i(dcmp_i),
        .sense_i(sense_i), .pin_en_i(pin_en_i), .dcmp_en_i(dcmp_en_i),
        .use_dcmp_i(use_dcmp_i), .latch_en_i(latch_en_i),
        .minper_en_i(minper_en_i), .minper_i(minper_i), .clr_i(clr_i),
        .pwm_i(pwm_i), .safe_val_i(safe_val_i), .pwm_o(pwm_o),
        .fault_o(fault_o), .status_o(status_o), .pin_stat_o(pin_stat_o),
        .dcmp_stat_o(dcmp_stat_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Driver side: queue an expectation dly cycles from now.
    task automatic expect_at(int dly, logic [7:0] pwm, logic flt, logic [3:0] st,
                             logic chk_ps, logic [3:0] ps, string req);
        exp_t e;
        e.at = cyc + dly; e.pwm = pwm; e.flt = flt; e.st = st;
        e.chk_ps = chk_ps; e.ps = ps; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare due expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (pwm_o !== e.pwm || fault_o !== e.flt || status_o !== e.st ||
                    (e.chk_ps && pin_stat_o !== e.ps)) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d actual pwm=%h flt=%b st=%b ps=%b expected pwm=%h flt=%b st=%b ps=%b",
                             e.req, cyc, pwm_o, fault_o, status_o, pin_stat_o,
                             e.pwm, e.flt, e.st, e.ps);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b1, 4'b0000, "R1 reset");
        tick(2);

        // R2/R4/R6: plain active-high pin 0.
        pin_en_i = 4'b0001;
        fault_pin_i[0] = 1'b1;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b1, 4'b0000, "R2 first flop");
        expect_at(2, PASS, 1'b0, 4'b0000, 1'b1, 4'b0001, "R2 synced");
        expect_at(3, SAFE, 1'b1, 4'b0001, 1'b1, 4'b0001, "R4 override");
        tick(5);
        fault_pin_i[0] = 1'b0;
        expect_at(3, PASS, 1'b0, 4'b0001, 1'b0, 4'b0000, "R6 sticky after release");
        tick(5);
        clr_i = 4'b0001;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b0, 4'b0000, "R6 cleared");
        tick(1);
        clr_i = '0;
        tick(2);

        // R6: clear while the source is still active.
        fault_pin_i[0] = 1'b1;
        tick(4);
        clr_i = 4'b0001;
        expect_at(1, SAFE, 1'b1, 4'b0001, 1'b0, 4'b0000, "R6 input wins");
        tick(1);
        clr_i = '0;
        fault_pin_i[0] = 1'b0;
        tick(4);
        clr_i = 4'b0001;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b0, 4'b0000, "R6 cleared");
        tick(1);
        clr_i = '0;
        tick(2);

        // R3: active-low pin 1, then a disabled pin 2.
        fault_pin_i[1] = 1'b1;
        tick(3);
        sense_i = 4'b0010;
        pin_en_i = 4'b0011;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b1, 4'b0000, "R3 low-active idle high");
        tick(3);
        fault_pin_i[1] = 1'b0;
        expect_at(3, SAFE, 1'b1, 4'b0010, 1'b1, 4'b0010, "R3 low-active fault");
        tick(5);
        fault_pin_i[1] = 1'b1;
        tick(4);
        clr_i = 4'b0010;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b1, 4'b0000, "R3 released");
        tick(1);
        clr_i = '0;
        fault_pin_i[2] = 1'b1;
        expect_at(4, PASS, 1'b0, 4'b0000, 1'b1, 4'b0000, "R3 disabled pin");
        tick(5);
        fault_pin_i[2] = 1'b0;
        tick(3);

        // R5: comparator condition gated by the source selector.
        dcmp_en_i = 4'b0001;
        dcmp_i = 4'b0001;
        expect_at(3, PASS, 1'b0, 4'b0000, 1'b1, 4'b0000, "R5 deselected");
        tick(4);
        use_dcmp_i = 1'b1;
        expect_at(1, SAFE, 1'b1, 4'b0001, 1'b1, 4'b0000, "R5 selected");
        tick(3);
        dcmp_i = '0;
        expect_at(1, PASS, 1'b0, 4'b0001, 1'b1, 4'b0000, "R5 released");
        tick(2);
        clr_i = 4'b0001;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b0, 4'b0000, "R6 cleared");
        tick(1);
        clr_i = '0;
        use_dcmp_i = 1'b0;
        tick(2);

        // R7: latch mode.
        latch_en_i = 1'b1;
        fault_pin_i[0] = 1'b1;
        expect_at(3, SAFE, 1'b1, 4'b0001, 1'b0, 4'b0000, "R7 fault");
        tick(4);
        fault_pin_i[0] = 1'b0;
        expect_at(6, SAFE, 1'b1, 4'b0001, 1'b0, 4'b0000, "R7 held");
        tick(8);
        clr_i = 4'b0001;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b0, 4'b0000, "R7 cleared");
        tick(1);
        clr_i = '0;
        latch_en_i = 1'b0;
        tick(2);

        // R8: one-cycle pulse stretched by N = 5.
        minper_en_i = 1'b1;
        minper_i = 16'd5;
        fault_pin_i[0] = 1'b1;
        expect_at(2, PASS, 1'b0, 4'b0000, 1'b0, 4'b0000, "R8 before");
        expect_at(3, SAFE, 1'b1, 4'b0001, 1'b0, 4'b0000, "R8 start");
        expect_at(8, SAFE, 1'b1, 4'b0001, 1'b0, 4'b0000, "R8 last stretched");
        expect_at(9, PASS, 1'b0, 4'b0001, 1'b0, 4'b0000, "R8 end");
        tick(1);
        fault_pin_i[0] = 1'b0;
        tick(12);
        clr_i = 4'b0001;
        expect_at(1, PASS, 1'b0, 4'b0000, 1'b0, 4'b0000, "R6 cleared");
        tick(1);
        clr_i = '0;
        minper_en_i = 1'b0;

        tick(4);
        while (q.size() > 0) tick(1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule